// File: doc/BRIEF.md
# Bitfield Extract and Insert Unit

This unit works on 32-bit words and performs one of two field operations per request. Extract takes a run of adjacent bits from a source word and returns it right-justified, with all higher bits zero. Insert takes the low bits of a source value and writes them into a run of adjacent bits of a destination word. Every destination bit outside that run keeps its value.

A single 9-bit field operand describes the run. It holds a start bit index and a width code, so software needs no separate shift and mask steps around a port read or write. The result is registered. It appears one clock after the request, together with a one-cycle valid strobe.

Top module: `bitfield_unit`

## Requirements
- R1: A synchronous active-high `rst` sets `result` to zero and deasserts `res_valid` at the next rising clock edge.
- R2: `res_valid` is high exactly in the cycle after a cycle with `req_valid` high, and `result` changes only on such a request; without a request it holds its value.
- R3: In `field_spec`, bits 8:4 give the start position P (0 to 31) and bits 3:0 give the width code.
- R4: Width codes 1 to 15 select that many bits, and width code 0 selects 16 bits.
- R5: With `req_insert` low (extract), `result` bit k equals `src` bit P+k for every k below the width with P+k ≤ 31.
- R6: On extract, every `result` bit at or above the width, and every bit whose source index would pass bit 31, is zero.
- R7: With `req_insert` high (insert), `result` bit P+k equals `src` bit k for each k below the width with P+k ≤ 31.
- R8: On insert, every `result` bit outside the field equals the corresponding `dst` bit.
- R9: A field with P plus width above 32 is cut off at bit 31, and neither operation wraps any bit into the low end of the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe |
| req_insert | input | 1 | Operation select: 0 extract, 1 insert |
| src | input | 32 | Word to extract from, or value to insert |
| dst | input | 32 | Destination word for insert |
| field_spec | input | 9 | {start position[8:4], width code[3:0]} |
| result | output | 32 | Registered result |
| res_valid | output | 1 | High for one cycle with each new result |

## Verification
A wrong mask width or shift direction shows in the very next `result` after a request. It shows as a field that is too short or misplaced, or as stray high bits on extract. A flawed merge on insert shows as changed destination bits outside the field in that same result. A faulty valid or hold path shows as a strobe without a request, or as `result` drifting during idle cycles, already in the first idle cycle. Fields at the top of the word expose any wrap-around of bits.

// File: rtl/bitfield_unit.sv
module bitfield_unit #(
  parameter int DATA_W  = 32,
  parameter int POS_W   = 5,
  parameter int WCODE_W = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  input  logic                       req_insert,
  input  logic [DATA_W-1:0]          src,
  input  logic [DATA_W-1:0]          dst,
  input  logic [POS_W+WCODE_W-1:0]   field_spec,
  output logic [DATA_W-1:0]          result,
  output logic                       res_valid
);
  localparam int SPEC_W = POS_W + WCODE_W;
  localparam int FULL_W = 1 << WCODE_W;

  logic [POS_W-1:0]   pos;
  logic [WCODE_W-1:0] wcode;
  logic [WCODE_W:0]   width;
  logic [DATA_W-1:0]  low_mask, field_mask, extracted, placed, diff, next_res;

  assign pos        = field_spec[SPEC_W-1:WCODE_W];
  assign wcode      = field_spec[WCODE_W-1:0];
  assign width      = (wcode == '0) ? FULL_W[WCODE_W:0] : {1'b0, wcode};
  assign low_mask   = ~({DATA_W{1'b1}} << width);
  assign field_mask = low_mask << pos;
  assign extracted  = (src >> pos) & low_mask;
  assign placed     = (src & low_mask) << pos;
  assign diff       = (placed ^ dst) & field_mask;
  assign next_res   = req_insert ? (dst ^ diff) : extracted;

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) result <= next_res;
    end
  end
endmodule

// File: rtl/bitfield_unit_chk.sv
module bitfield_unit_chk #(
  parameter int DATA_W  = 32,
  parameter int POS_W   = 5,
  parameter int WCODE_W = 4
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     req_valid,
  input logic                     req_insert,
  input logic [DATA_W-1:0]        src,
  input logic [DATA_W-1:0]        dst,
  input logic [POS_W+WCODE_W-1:0] field_spec,
  input logic [DATA_W-1:0]        result,
  input logic                     res_valid
);
  function automatic logic [DATA_W-1:0] span(input logic [POS_W+WCODE_W-1:0] fs);
    int p, w;
    logic [DATA_W-1:0] m;
    p = int'(fs[POS_W+WCODE_W-1:WCODE_W]);
    w = (fs[WCODE_W-1:0] == '0) ? (1 << WCODE_W) : int'(fs[WCODE_W-1:0]);
    m = '0;
    for (int i = 0; i < DATA_W; i++) if (i >= p && i < p + w) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] low_ones(input logic [POS_W+WCODE_W-1:0] fs);
    int w;
    logic [DATA_W-1:0] m;
    w = (fs[WCODE_W-1:0] == '0) ? (1 << WCODE_W) : int'(fs[WCODE_W-1:0]);
    m = '0;
    for (int i = 0; i < DATA_W; i++) if (i < w) m[i] = 1'b1;
    return m;
  endfunction

  a_r1_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (!res_valid && result == '0));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !res_valid);

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(result));

  a_r6_extract_high_zero: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_insert) |=> ((result & ~$past(low_ones(field_spec))) == '0));

  a_r8_insert_outside: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_insert) |=> (((result ^ $past(dst)) & ~$past(span(field_spec))) == '0));
endmodule

bind bitfield_unit bitfield_unit_chk #(
  .DATA_W(DATA_W), .POS_W(POS_W), .WCODE_W(WCODE_W)
) u_chk (.*);

// File: tb/bitfield_unit_bench.sv
module bitfield_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_insert = 1'b0;
  logic [31:0] src = '0;
  logic [31:0] dst = '0;
  logic [8:0]  field_spec = '0;
  logic [31:0] result;
  logic        res_valid;

  int compared = 0;
  int mismatched = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] last_res = '0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  bitfield_unit u_bitfield_unit (.*);

  function automatic logic [31:0] model(input bit ins, input logic [31:0] s,
                                        input logic [31:0] d, input int p, input int wc);
    int w;
    logic [31:0] r;
    w = (wc == 0) ? 16 : wc;
    r = ins ? d : 32'h0;
    for (int k = 0; k < w; k++)
      if (p + k <= 31) begin
        if (ins) r[p+k] = s[k];
        else     r[k]   = s[p+k];
      end
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input string tag, input bit ins, input logic [31:0] s,
                       input logic [31:0] d, input int p, input int wc);
    @(negedge clk);
    req_valid  = 1'b1;
    req_insert = ins;
    src        = s;
    dst        = d;
    field_spec = {p[4:0], wc[3:0]};
    exp_q.push_back(model(ins, s, d, p, wc));
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
    src = $urandom;
    dst = $urandom;
  endtask

  always @(negedge clk) begin
    #1;
    if (!rst && !done) begin
      if (res_valid) begin
        if (exp_q.size() == 0) begin
          check("R2 strobe without request", {31'b0, res_valid}, 32'h0);
        end else begin
          check(tag_q.pop_front(), result, exp_q.pop_front());
          last_res = result;
        end
      end else if (result !== last_res) begin
        check("R2 hold while idle", result, last_res);
      end
    end
  end

  initial begin
    #4_000_000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset result", result, 32'h0);
    check("R1 reset valid", {31'b0, res_valid}, 32'h0);
    rst = 1'b0;

    issue("R3 R5 extract low byte",       1'b0, 32'hA5C3_7E19, '0, 0, 8);
    issue("R3 R5 extract pos 22 w8",      1'b0, 32'hA5C3_7E19, '0, 22, 8);
    issue("R4 extract code 0 is 16 bits", 1'b0, 32'hDEAD_BEEF, '0, 8, 0);
    issue("R6 extract w1 pos 31",         1'b0, 32'h8000_0000, '0, 31, 1);
    issue("R9 R6 extract truncated top",  1'b0, 32'hFFFF_FFFF, '0, 28, 8);
    issue("R6 R4 extract all ones w16",   1'b0, 32'hFFFF_FFFF, '0, 3, 0);
    issue("R8 R7 insert nibble",          1'b1, 32'h0000_000A, 32'h1234_5678, 12, 4);
    issue("R7 R8 insert ignores high src",1'b1, 32'hFFFF_FF00, 32'h0F0F_0F0F, 4, 8);
    issue("R4 R7 insert 16 bits",         1'b1, 32'h0000_BEEF, 32'hFFFF_FFFF, 16, 0);
    issue("R9 R8 insert truncated top",   1'b1, 32'h0000_00FF, 32'h0000_0000, 30, 8);
    issue("R8 insert equal bits no change",1'b1, 32'h0000_0005, 32'h0000_0050, 4, 4);
    issue("R8 insert w15 pos 0",          1'b1, 32'h0000_0000, 32'hFFFF_FFFF, 0, 15);
    repeat (4) @(negedge clk);

    for (int i = 0; i < 40; i++) begin
      logic [31:0] s, d;
      s = $urandom; d = $urandom;
      issue((i % 2) ? "R7 R8 random insert" : "R5 R6 random extract",
            bit'(i % 2), s, d, int'($urandom_range(31, 0)), int'($urandom_range(15, 0)));
      if (i % 5 == 0) repeat (2) @(negedge clk);
    end

    repeat (3) @(negedge clk);
    check("R2 all results delivered", exp_q.size(), 32'h0);
    rst = 1'b1;
    @(negedge clk);
    #2;
    check("R1 reset mid-run result", result, 32'h0);
    check("R1 reset mid-run valid", {31'b0, res_valid}, 32'h0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule